// File: doc/BRIEF.md
# Mode-Dependent Character Register File

This block stores one byte per display digit for a matrix display controller. A register bus writes and reads these bytes. The address decoding depends on two inputs: a display-mode bit and a grid-count value `g`.

In one-row mode, a single row of up to 48 characters sits at the lower address window. The upper window always holds 48 annunciator bytes. In two-row mode, the upper window instead holds a second row of characters. That second window is sized by `g` in the same way as the first. The annunciator bytes and the second-row characters share the same physical cells, so switching modes changes only how the cells are interpreted.

A combinational scan port lets a refresh engine fetch the byte for any row and grid in the same cycle it asks. The byte is split into a 7-bit character index and a decimal-point flag. Accesses outside the active windows are discarded on write and read back as zero. All cells clear on reset.

Top module: `char_regfile`

## Requirements
- R1: In one-row mode (`mode_i`=0), addresses 0x20 to 0x20+g select row-zero cells 0 to g. Row-zero cell n is always at address 0x20+n.
- R2: In one-row mode, addresses 0x50 to 0x7F select the 48 annunciator cells 0 to 47, whatever the value of g.
- R3: In two-row mode (`mode_i`=1), row zero is at 0x20 to 0x20+g and row one is at 0x50 to 0x50+g. With g=47 the two rows form one run from 0x20 to 0x7F.
- R4: A write to any address outside the active windows for the current mode and g changes no cell.
- R5: A bus read of any address outside the active windows returns 0x00.
- R6: A grid value above 47 acts as 47.
- R7: While `rst_ni` is low, every cell reads as 0x00.
- R8: Changing `mode_i` keeps all contents. Annunciator cell n and row-one character cell n are the same storage.
- R9: The scan port is combinational and reads the byte at (`scan_row_i`, `scan_grid_i`). `scan_dp_o` is bit 7 of that byte and `scan_char_o` is bits 6:0. Row 1 in one-row mode returns annunciator cell n. A grid above g returns all zeros.
- R10: A write with `wr_en_i` high is visible on `rdata_o` for the same address from the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 selects one row plus annunciators, 1 selects two rows |
| grids_i | input | 6 | Highest grid index g |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 8 | Bus address for both write and read |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Combinational bus read data |
| scan_row_i | input | 1 | Scan row select |
| scan_grid_i | input | 6 | Scan grid index |
| scan_char_o | output | 7 | Character index of the scanned digit |
| scan_dp_o | output | 1 | Decimal point of the scanned digit |

## Verification
The bench uses the default parameters: 48 grids, with windows based at 0x20 and 0x50. This places both window edges inside the 8-bit address space, so the full g=47 span, the 0x4F/0x50 seam, the 0x7F top and the 0x80 overflow are all reachable.

Because `grids_i` is 6 bits wide, it can carry values up to 63. This lets the bench drive g above the clamp point of 47.

## Rationale
The table of vectors changes g between writes. This shows that a cell written under a wide window reads back as zero under a narrow one, while its contents survive. It also shows that annunciator data written in one mode reappears as row-one characters in the other.

// File: rtl/charfile_pkg.sv
package charfile_pkg;
  typedef enum logic {
    MODE_ONE_ROW = 1'b0,
    MODE_TWO_ROW = 1'b1
  } disp_mode_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/charfile_decode.sv
module charfile_decode
  import charfile_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned GRID_W    = 6,
  parameter int unsigned MAX_GRIDS = 48,
  parameter int unsigned BASE0     = 'h20,
  parameter int unsigned BASE1     = 'h50
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  disp_mode_e        mode_i,
  input  logic [GRID_W-1:0] g_eff_i,
  output logic              sel0_o,
  output logic              sel1_o,
  output logic [GRID_W-1:0] idx_o
);
  localparam logic [ADDR_W-1:0] B0   = ADDR_W'(BASE0);
  localparam logic [ADDR_W-1:0] B1   = ADDR_W'(BASE1);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(MAX_GRIDS - 1);

  logic [ADDR_W-1:0] off0, off1, g_w, lim1;

  always_comb begin
    off0 = addr_i - B0;
    off1 = addr_i - B1;
    g_w  = ADDR_W'(g_eff_i);
    // upper window: fixed full size for annunciators, g-sized for row one
    lim1 = (mode_i == MODE_ONE_ROW) ? LAST : g_w;
    sel0_o = (addr_i >= B0) && (off0 <= g_w);
    sel1_o = (addr_i >= B1) && (off1 <= lim1);
    idx_o  = sel1_o ? off1[GRID_W-1:0] : off0[GRID_W-1:0];
  end
endmodule

// File: rtl/charfile_bank.sv
module charfile_bank #(
  parameter int unsigned DEPTH  = 48,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  bus_idx_i,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic [IDX_W-1:0]  scan_idx_i,
  output logic [DATA_W-1:0] scan_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && (int'(widx_i) < DEPTH)) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  always_comb begin
    bus_data_o  = (int'(bus_idx_i)  < DEPTH) ? mem_q[bus_idx_i]  : '0;
    scan_data_o = (int'(scan_idx_i) < DEPTH) ? mem_q[scan_idx_i] : '0;
  end
endmodule

// File: rtl/charfile_scan.sv
module charfile_scan #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GRID_W = 6
) (
  input  logic              row_i,
  input  logic [GRID_W-1:0] grid_i,
  input  logic [GRID_W-1:0] g_eff_i,
  input  logic [DATA_W-1:0] bank0_i,
  input  logic [DATA_W-1:0] bank1_i,
  output logic [DATA_W-2:0] char_o,
  output logic              dp_o
);
  logic [DATA_W-1:0] byte_sel;

  always_comb begin
    byte_sel = row_i ? bank1_i : bank0_i;
    if (grid_i > g_eff_i) byte_sel = '0;
    char_o = byte_sel[DATA_W-2:0];
    dp_o   = byte_sel[DATA_W-1];
  end
endmodule

// File: rtl/char_regfile.sv
module char_regfile
  import charfile_pkg::*;
#(
  parameter int unsigned MAX_GRIDS = 48,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BASE0     = 'h20,
  parameter int unsigned BASE1     = 'h50,
  localparam int unsigned GRID_W   = $clog2(MAX_GRIDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [GRID_W-1:0] grids_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              scan_row_i,
  input  logic [GRID_W-1:0] scan_grid_i,
  output logic [DATA_W-2:0] scan_char_o,
  output logic              scan_dp_o
);
  localparam logic [GRID_W-1:0] G_MAX = GRID_W'(MAX_GRIDS - 1);

  disp_mode_e        mode;
  logic [GRID_W-1:0] g_eff;
  logic              sel0, sel1;
  logic [GRID_W-1:0] idx;
  logic [NUM_BANKS-1:0] sel_vec;
  logic [DATA_W-1:0] bus_rd  [NUM_BANKS];
  logic [DATA_W-1:0] scan_rd [NUM_BANKS];

  assign mode    = disp_mode_e'(mode_i);
  assign g_eff   = (grids_i > G_MAX) ? G_MAX : grids_i;
  assign sel_vec = {sel1, sel0};

  charfile_decode #(
    .ADDR_W(ADDR_W), .GRID_W(GRID_W), .MAX_GRIDS(MAX_GRIDS),
    .BASE0(BASE0), .BASE1(BASE1)
  ) u_dec (
    .addr_i(addr_i), .mode_i(mode), .g_eff_i(g_eff),
    .sel0_o(sel0), .sel1_o(sel1), .idx_o(idx)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    charfile_bank #(.DEPTH(MAX_GRIDS), .DATA_W(DATA_W), .IDX_W(GRID_W)) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .we_i(wr_en_i && sel_vec[b]),
      .widx_i(idx), .wdata_i(wdata_i),
      .bus_idx_i(idx), .bus_data_o(bus_rd[b]),
      .scan_idx_i(scan_grid_i), .scan_data_o(scan_rd[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (sel0)      rdata_o = bus_rd[0];
    else if (sel1) rdata_o = bus_rd[1];
  end

  charfile_scan #(.DATA_W(DATA_W), .GRID_W(GRID_W)) u_scan (
    .row_i(scan_row_i), .grid_i(scan_grid_i), .g_eff_i(g_eff),
    .bank0_i(scan_rd[0]), .bank1_i(scan_rd[1]),
    .char_o(scan_char_o), .dp_o(scan_dp_o)
  );
endmodule

// File: rtl/char_regfile_chk.sv
module char_regfile_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned GRID_W = 6,
  parameter int unsigned BASE0  = 'h20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_i,
  input logic [GRID_W-1:0] grids_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              scan_row_i,
  input logic [GRID_W-1:0] scan_grid_i,
  input logic [DATA_W-2:0] scan_char_o,
  input logic              scan_dp_o
);
  localparam logic [ADDR_W-1:0] B0 = ADDR_W'(BASE0);

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (rdata_o == '0 && scan_char_o == '0 && !scan_dp_o)); // R7

  AST_BELOW_WINDOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < B0) |-> (rdata_o == '0)); // R5

  AST_NO_WRITE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && $stable(addr_i) && $stable(mode_i) && $stable(grids_i))
      |=> (!$stable(addr_i) || !$stable(mode_i) || !$stable(grids_i) || $stable(rdata_o))); // R4

  AST_FIRST_CELL_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == B0)
      |=> (addr_i != $past(addr_i) || rdata_o == $past(wdata_i))); // R10

  AST_SCAN_MATCHES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_row_i && scan_grid_i == '0 && addr_i == B0)
      |-> ({scan_dp_o, scan_char_o} == rdata_o)); // R9
endmodule

bind char_regfile char_regfile_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRID_W(GRID_W), .BASE0(BASE0)
) u_chk (.*);

// File: tb/sim_char_regfile.sv
module sim_char_regfile;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0;
  logic [5:0] grids_i = 6'd47;
  logic       wr_en_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       scan_row_i = 1'b0;
  logic [5:0] scan_grid_i = 6'd0;
  logic [6:0] scan_char_o;
  logic       scan_dp_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  char_regfile u0 (.*);

  typedef struct packed {
    logic       mode;
    logic [5:0] g;
    logic [7:0] waddr;
    logic [7:0] wdata;
    logic [7:0] raddr;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd47, 8'h20, 8'h41, 8'h20, 8'h41}, // R1 R10
    '{1'b0, 6'd47, 8'h4F, 8'hC2, 8'h4F, 8'hC2}, // R1 top of row zero
    '{1'b0, 6'd5,  8'h26, 8'h11, 8'h26, 8'h00}, // R4 R5 above 0x20+g
    '{1'b0, 6'd47, 8'h50, 8'h7E, 8'h50, 8'h7E}, // R2 annunciator 0
    '{1'b0, 6'd47, 8'h7F, 8'h33, 8'h7F, 8'h33}, // R2 annunciator 47
    '{1'b0, 6'd47, 8'h10, 8'h55, 8'h26, 8'h00}, // R4 earlier write discarded
    '{1'b1, 6'd47, 8'h80, 8'h99, 8'h50, 8'h7E}, // R8 annunciator seen as row one
    '{1'b1, 6'd3,  8'h53, 8'h24, 8'h53, 8'h24}, // R3 row one edge
    '{1'b1, 6'd3,  8'h54, 8'h66, 8'h54, 8'h00}, // R4 R5 past row one
    '{1'b1, 6'd3,  8'h23, 8'h8A, 8'h23, 8'h8A}, // R3 row zero edge
    '{1'b1, 6'd3,  8'h7F, 8'h01, 8'h7F, 8'h00}, // R5 stored cell hidden
    '{1'b0, 6'd47, 8'h00, 8'h00, 8'h7F, 8'h33}, // R4 R8 cell kept
    '{1'b0, 6'd63, 8'h4F, 8'h12, 8'h4F, 8'h12}, // R6 clamp one-row
    '{1'b0, 6'd3,  8'h00, 8'h00, 8'h50, 8'h7E}, // R2 annunciator ignores g
    '{1'b1, 6'd63, 8'h7F, 8'h5A, 8'h7F, 8'h5A}, // R6 clamp two-row
    '{1'b1, 6'd47, 8'h00, 8'h00, 8'h4F, 8'h12}  // R3 contiguous run
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic scan_chk(input string req, input logic m, input logic [5:0] g,
                          input logic row, input logic [5:0] grid,
                          input logic [6:0] exp_c, input logic exp_dp);
    @(negedge clk_i);
    mode_i = m; grids_i = g; scan_row_i = row; scan_grid_i = grid;
    #1;
    chk(req, {scan_dp_o, scan_char_o}, {exp_dp, exp_c});
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R7 reset state
    @(negedge clk_i); @(negedge clk_i);
    addr_i = 8'h20; #1;
    chk("R7 reset bus", rdata_o, 8'h00);
    chk("R7 reset scan", {scan_dp_o, scan_char_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      mode_i = VECS[i].mode; grids_i = VECS[i].g;
      addr_i = VECS[i].waddr; wdata_i = VECS[i].wdata; wr_en_i = 1'b1;
      @(negedge clk_i);
      wr_en_i = 1'b0; addr_i = VECS[i].raddr;
      #1;
      chk($sformatf("R1-table vec%0d", i), rdata_o, VECS[i].exp);
    end

    // R9 scan, sampled without any clock edge in between
    scan_chk("R9 row0 grid0",   1'b1, 6'd47, 1'b0, 6'd0,  7'h41, 1'b0);
    scan_chk("R9 dp split",     1'b1, 6'd47, 1'b0, 6'd3,  7'h0A, 1'b1);
    scan_chk("R9 row1 grid47",  1'b1, 6'd47, 1'b1, 6'd47, 7'h5A, 1'b0);
    scan_chk("R9 annunciator",  1'b0, 6'd47, 1'b1, 6'd0,  7'h7E, 1'b0);
    scan_chk("R9 beyond g",     1'b1, 6'd2,  1'b0, 6'd3,  7'h00, 1'b0);

    // R7 reset mid-run clears both banks
    @(negedge clk_i);
    rst_ni = 1'b0; mode_i = 1'b0; grids_i = 6'd47; addr_i = 8'h20; #1;
    chk("R7 row zero cleared", rdata_o, 8'h00);
    addr_i = 8'h7F; #1;
    chk("R7 annunciator cleared", rdata_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1; #1;
    chk("R7 after release", rdata_o, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule